// File: doc/BRIEF.md
# SPI Master Transmitter with DMA-Aware Interrupt Routing

This block shifts 16-bit words out over a mode-0 SPI link. A CPU register write or a DMA engine loads the words into a small transmit queue. A shifter drains the queue MSB first, and chip select stays low for as long as any word is queued or still being shifted. A busy output follows the same span, so its falling edge marks the point where the last bit has actually left the pin.

Interrupts from three sources are combined onto one output line:

- **Transmit source.** It has two meanings, chosen by a mode bit. With the mode bit clear, it is a live queue-level condition. With the mode bit set, it is a sticky end-of-transmission event.
- **DMA-done source.** It is sticky and records that the DMA handed over the final word of its programmed count.
- **Receive-overrun source.** It is sticky and latches an external overrun pulse.

When DMA feeding is on, the queue-level source is kept off the line, and only DMA-done and overrun can reach it. With DMA on and end-of-transmission mode set, one transfer raises two interrupts: DMA-done first, then end-of-transmission once the shifter has drained. Software reads the raw and masked status vectors and clears sticky bits by writing 1.

Top module: `spi_tx_dmairq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0 and dma_req is 0. irq_raw reads 3'b001, with the queue-level bit set because the queue is empty.
- R2: Each word is sent MSB first in SPI mode 0. sclk idles low, and mosi holds steady while sclk is high, so the value at each rising sclk edge is the next data bit.
- R3: Each sclk half period lasts cfg_half_div+1 clock cycles, so one full sclk period is 2*(cfg_half_div+1) cycles.
- R4: busy is 1, and cs_n is 0, from the moment a word is queued until the last bit of the last queued word has been shifted out. Back-to-back words share one low period of cs_n.
- R5: With cfg_eot_mode=0, irq_raw bit 0 equals (queue entries <= 4). This bit is a level, and writing 1 to irq_clear bit 0 has no effect on it.
- R6: With cfg_eot_mode=1, irq_raw bit 0 sets on the cycle after busy falls and stays set until it is cleared.
- R7: irq_raw bit 2 (DMA-done) sets when dma_ack is accepted together with dma_last, while busy is still high.
- R8: dma_req is 1 exactly when cfg_enable and cfg_dma_en are both 1 and the queue has a free entry. CPU writes are ignored while cfg_dma_en=1.
- R9: With cfg_dma_en=1 and cfg_eot_mode=0, bit 0 never reaches irq_masked or irq. Bits 1 (receive overrun) and 2 (DMA-done) still do.
- R10: irq_masked is irq_raw AND irq_mask, after the routing rule in R9 is applied. irq is the OR of irq_masked.
- R11: Writing 1 to an irq_clear bit clears that sticky bit on the next cycle. If the bit is set and cleared in the same cycle, the set wins.
- R12: With cfg_dma_en=1 and cfg_eot_mode=1, one transfer gives two separate rising edges on irq. The first comes from DMA-done while busy is high. The second comes from end-of-transmission after busy has fallen.
- R13: With 8 entries queued, cpu_wr_ready is 0 and a further CPU write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Allows the shifter to start words |
| cfg_dma_en | input | 1 | Queue is fed by DMA instead of CPU |
| cfg_eot_mode | input | 1 | Transmit bit means end-of-transmission instead of queue level |
| cfg_half_div | input | DIV_W | sclk half period minus one, in clock cycles |
| irq_mask | input | 3 | Per-source interrupt enable |
| irq_clear | input | 3 | Write-1-to-clear pulses for sticky bits |
| irq_raw | output | 3 | Raw status: bit0 transmit, bit1 overrun, bit2 DMA-done |
| irq_masked | output | 3 | Masked and routed status |
| irq | output | 1 | Combined interrupt line |
| cpu_wr_valid | input | 1 | CPU word write strobe |
| cpu_wr_data | input | DATA_W | CPU word |
| cpu_wr_ready | output | 1 | CPU write would be accepted |
| dma_req | output | 1 | Request for one word from DMA |
| dma_ack | input | 1 | DMA delivers a word this cycle |
| dma_data | input | DATA_W | DMA word |
| dma_last | input | 1 | This DMA word completes the programmed count |
| rx_overrun | input | 1 | Receive overrun event pulse |
| busy | output | 1 | Words queued or shifting |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with DATA_W=16, DEPTH=8, LEVEL_THR=4 and DIV_W=4. An 8-entry queue can be filled by a handful of writes, so both sides of the level threshold and the full-queue drop are reachable in a short directed sequence. A 4-bit divider lets the sclk period be measured at both its smallest setting and a larger one. A 16-bit word at the small divider takes only about 64 cycles to shift, yet that is still long enough to observe DMA-done clearly before busy falls, and to see the separate end-of-transmission interrupt afterwards.

// File: rtl/spi_tx_pkg.sv
// Shared constants for the SPI transmitter: interrupt vector width and bit slots.
package spi_tx_pkg;
    localparam int IRQ_W   = 3;
    localparam int IRQ_TX  = 0;   // queue level or end-of-transmission
    localparam int IRQ_ROR = 1;   // receive overrun
    localparam int IRQ_DMA = 2;   // DMA programmed count handed over
endpackage

// File: rtl/spi_tx_fifo.sv
// Transmit word queue.
// Circular buffer with an occupancy count. Pushes while full and pops while
// empty are ignored. Assumes one push and one pop at most per cycle.
module spi_tx_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rd_ptr];

    // Store the accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers with wrap, and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R4
endmodule

// File: rtl/spi_tx_shifter.sv
// Mode-0 MSB-first serializer.
// Pulls a word from the queue when idle, or at the final falling sclk edge of
// the current word, so back-to-back words run without a gap. Each sclk
// half period lasts half_div+1 clocks. Assumes half_div is held steady during a word.
module spi_tx_shifter #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              have_word,
    input  logic [DATA_W-1:0] word,
    output logic              pop,
    output logic              active,
    output logic              sclk,
    output logic              mosi
);
    logic [DATA_W-1:0] sh;
    logic [DIV_W-1:0]  divcnt;
    logic [IDX_W-1:0]  bit_idx;
    logic              tick, last_fall;

    assign tick      = active && (divcnt == half_div);
    assign last_fall = tick && sclk && (bit_idx == '0);
    assign pop       = enable && have_word && (!active || last_fall);
    assign mosi      = active ? sh[DATA_W-1] : 1'b0;

    // Load, toggle sclk on divider ticks, shift on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            divcnt  <= '0;
            bit_idx <= '0;
            active  <= 1'b0;
            sclk    <= 1'b0;
        end else if (pop) begin
            sh      <= word;
            divcnt  <= '0;
            bit_idx <= IDX_W'(DATA_W - 1);
            active  <= 1'b1;
            sclk    <= 1'b0;
        end else if (active) begin
            if (tick) begin
                divcnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bit_idx == '0) begin
                        active <= 1'b0;
                    end else begin
                        sh      <= sh << 1;
                        bit_idx <= bit_idx - 1'b1;
                    end
                end
            end else begin
                divcnt <= divcnt + 1'b1;
            end
        end
    end

    AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));  // R2
endmodule

// File: rtl/spi_tx_irq.sv
// Interrupt status, routing and masking.
// The transmit bit is a live level (queue at or below threshold) or a sticky
// end-of-transmission flag, depending on eot_mode. The DMA-done and overrun
// bits are sticky with write-1-to-clear, and a set wins over a clear.
// In DMA mode the level source is kept off the line.
module spi_tx_irq
    import spi_tx_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int LEVEL_THR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eot_mode,
    input  logic             dma_en,
    input  logic [IRQ_W-1:0] mask,
    input  logic [IRQ_W-1:0] clear,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             busy,
    input  logic             dma_done_evt,
    input  logic             ovr_evt,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    logic busy_q, eot_q, dma_q, ovr_q, eot_set;
    logic [IRQ_W-1:0] route;

    assign eot_set = eot_mode && busy_q && !busy;

    // Track busy, and latch the sticky sources with write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            eot_q  <= 1'b0;
            dma_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            busy_q <= busy;
            eot_q  <= eot_set      || (eot_q && !clear[IRQ_TX]);
            dma_q  <= dma_done_evt || (dma_q && !clear[IRQ_DMA]);
            ovr_q  <= ovr_evt      || (ovr_q && !clear[IRQ_ROR]);
        end
    end

    // Build the raw vector, apply DMA-mode routing and the mask.
    always_comb begin
        raw           = '0;
        raw[IRQ_TX]   = eot_mode ? eot_q : (fifo_count <= CNT_W'(LEVEL_THR));
        raw[IRQ_ROR]  = ovr_q;
        raw[IRQ_DMA]  = dma_q;
        route         = '1;
        route[IRQ_TX] = !dma_en || eot_mode;
        masked        = raw & mask & route;
        irq           = |masked;
    end

    AST_DMADONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw[IRQ_DMA]) && !$past(clear[IRQ_DMA])) |-> raw[IRQ_DMA]);  // R11
endmodule

// File: rtl/spi_tx_dmairq.sv
// SPI master transmit path with DMA-aware interrupt routing.
// The queue is fed by the CPU, or by a DMA request/acknowledge handshake when
// cfg_dma_en is set. CS and busy cover every queued and shifting word.
// Assumes the DMA engine only acknowledges while dma_req is high.
module spi_tx_dmairq
    import spi_tx_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 8,
    parameter int LEVEL_THR = 4,
    parameter int DIV_W     = 8,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_dma_en,
    input  logic              cfg_eot_mode,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic [IRQ_W-1:0]  irq_mask,
    input  logic [IRQ_W-1:0]  irq_clear,
    output logic [IRQ_W-1:0]  irq_raw,
    output logic [IRQ_W-1:0]  irq_masked,
    output logic              irq,
    input  logic              cpu_wr_valid,
    input  logic [DATA_W-1:0] cpu_wr_data,
    output logic              cpu_wr_ready,
    output logic              dma_req,
    input  logic              dma_ack,
    input  logic [DATA_W-1:0] dma_data,
    input  logic              dma_last,
    input  logic              rx_overrun,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);
    logic              push, pop, full, empty, active;
    logic [DATA_W-1:0] push_data, pop_data;
    logic [CNT_W-1:0]  count;

    // Select the queue feeder by mode.
    always_comb begin
        push      = cfg_dma_en ? dma_ack  : cpu_wr_valid;
        push_data = cfg_dma_en ? dma_data : cpu_wr_data;
    end

    assign cpu_wr_ready = !cfg_dma_en && !full;
    assign dma_req      = cfg_enable && cfg_dma_en && !full;
    assign busy         = active || !empty;
    assign cs_n         = !busy;

    spi_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .count(count), .full(full), .empty(empty)
    );

    spi_tx_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .half_div(cfg_half_div),
        .have_word(!empty), .word(pop_data), .pop(pop), .active(active),
        .sclk(sclk), .mosi(mosi)
    );

    spi_tx_irq #(.CNT_W(CNT_W), .LEVEL_THR(LEVEL_THR)) u_irq (
        .clk(clk), .rst_n(rst_n), .eot_mode(cfg_eot_mode), .dma_en(cfg_dma_en),
        .mask(irq_mask), .clear(irq_clear), .fifo_count(count), .busy(busy),
        .dma_done_evt(cfg_dma_en && dma_ack && dma_last), .ovr_evt(rx_overrun),
        .raw(irq_raw), .masked(irq_masked), .irq(irq)
    );

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);  // R4
    AST_DMA_REQ_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (count < CNT_W'(DEPTH)));  // R8
endmodule

// File: tb/spi_tx_dmairq_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module spi_tx_dmairq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic clk = 0, rst_n = 0;
    logic cfg_enable = 0, cfg_dma_en = 0, cfg_eot_mode = 0;
    logic [3:0] cfg_half_div = 4'd1;
    logic [2:0] irq_mask = 0, irq_clear = 0, irq_raw, irq_masked;
    logic irq, cpu_wr_valid = 0, cpu_wr_ready, dma_req, dma_ack = 0, dma_last = 0;
    logic [DW-1:0] cpu_wr_data = 0, dma_data = 0;
    logic rx_overrun = 0, busy, sclk, mosi, cs_n;

    int checks = 0, errors = 0;
    int rx_n = 0, bits = 0, cs_rises = 0, irq_rises = 0, cyc = 0, last_rise = 0, period = 0;
    logic [DW-1:0] shreg = 0;
    logic [DW-1:0] rx_words [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_tx_dmairq #(.DATA_W(16), .DEPTH(8), .LEVEL_THR(4), .DIV_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_dma_en(cfg_dma_en),
        .cfg_eot_mode(cfg_eot_mode), .cfg_half_div(cfg_half_div), .irq_mask(irq_mask),
        .irq_clear(irq_clear), .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq),
        .cpu_wr_valid(cpu_wr_valid), .cpu_wr_data(cpu_wr_data), .cpu_wr_ready(cpu_wr_ready),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_data(dma_data), .dma_last(dma_last),
        .rx_overrun(rx_overrun), .busy(busy), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    // Serial monitor: capture bits at rising sclk, measure the sclk period.
    always @(posedge clk) cyc++;
    always @(posedge sclk) begin
        period    = cyc - last_rise;
        last_rise = cyc;
        shreg     = {shreg[DW-2:0], mosi};
        bits++;
        if (bits == DW) begin
            if (rx_n < 16) rx_words[rx_n] = shreg;
            rx_n++;
            bits = 0;
        end
    end
    always @(posedge cs_n) cs_rises++;
    always @(posedge irq) irq_rises++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        rx_n = 0; bits = 0; cs_rises = 0; irq_rises = 0;
    endtask

    task automatic cpu_write(input logic [DW-1:0] d);
        @(negedge clk); cpu_wr_valid = 1; cpu_wr_data = d;
        @(negedge clk); cpu_wr_valid = 0;
    endtask

    task automatic pulse_clear(input logic [2:0] c);
        @(negedge clk); irq_clear = c;
        @(negedge clk); irq_clear = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0);
        chk("R1 busy", busy, 0); chk("R1 dma_req", dma_req, 0);
        chk("R1 raw", irq_raw, 3'b001);
    endtask

    task automatic t_cpu_words();
        mon_clear(); cfg_enable = 1; cfg_half_div = 1;
        cpu_write(16'hA5C3); cpu_write(16'h0F01);
        @(negedge clk); chk("R4 busy during", busy, 1); chk("R4 cs_n during", cs_n, 0);
        wait_idle();
        chk("R2 word count", rx_n, 2);
        chk("R2 word0", rx_words[0], 16'hA5C3);
        chk("R2 word1", rx_words[1], 16'h0F01);
        chk("R4 single cs burst", cs_rises, 1);
        chk("R4 sclk idle", sclk, 0);
    endtask

    task automatic t_divider();
        cfg_half_div = 0; mon_clear(); cpu_write(16'h1234); wait_idle();
        chk("R3 period div0", period, 2);
        chk("R2 word div0", rx_words[0], 16'h1234);
        cfg_half_div = 3; mon_clear(); cpu_write(16'h8001); wait_idle();
        chk("R3 period div3", period, 8);
        chk("R2 word div3", rx_words[0], 16'h8001);
        cfg_half_div = 1;
    endtask

    task automatic t_level();
        cfg_enable = 0; irq_mask = 3'b001; mon_clear();
        for (int i = 0; i < 4; i++) cpu_write(16'h1100 + 16'(i));
        chk("R5 level at 4", irq_raw[0], 1);
        chk("R10 irq level", irq, 1);
        pulse_clear(3'b001);
        chk("R5 clear ignored", irq_raw[0], 1);
        cpu_write(16'h1104);
        chk("R5 level at 5", irq_raw[0], 0);
        chk("R10 irq off", irq, 0);
        for (int i = 5; i < 8; i++) cpu_write(16'h1100 + 16'(i));
        chk("R13 ready when full", cpu_wr_ready, 0);
        cpu_write(16'hDEAD);
        cfg_enable = 1; wait_idle();
        chk("R13 eight words", rx_n, 8);
        chk("R13 last word kept", rx_words[7], 16'h1107);
        chk("R13 first word", rx_words[0], 16'h1100);
        irq_mask = 0;
    endtask

    task automatic t_eot();
        cfg_eot_mode = 1; pulse_clear(3'b111); irq_mask = 3'b001; mon_clear();
        cpu_write(16'h5A5A);
        @(negedge clk);
        chk("R6 not yet", irq_raw[0], 0); chk("R10 irq low", irq, 0);
        wait_idle();
        chk("R6 eot set", irq_raw[0], 1); chk("R10 irq eot", irq, 1);
        repeat (5) @(negedge clk);
        chk("R6 sticky", irq_raw[0], 1);
        pulse_clear(3'b001);
        chk("R11 cleared", irq_raw[0], 0);
        cfg_eot_mode = 0; irq_mask = 0;
    endtask

    task automatic dma_send(input int n, input logic [DW-1:0] base);
        int sent = 0, guard = 0;
        while (sent < n && guard < 5000) begin
            @(negedge clk); guard++;
            if (dma_req) begin
                dma_ack = 1; dma_data = base + DW'(sent); dma_last = (sent == n - 1); sent++;
            end else begin
                dma_ack = 0; dma_last = 0;
            end
        end
        @(negedge clk); dma_ack = 0; dma_last = 0;
    endtask

    task automatic t_dma();
        cfg_enable = 0; cfg_dma_en = 1; cfg_eot_mode = 0; irq_mask = 3'b111;
        pulse_clear(3'b111);
        chk("R8 req off when disabled", dma_req, 0);
        chk("R9 level raw", irq_raw[0], 1);
        chk("R9 level gated", irq_masked, 3'b000);
        chk("R9 irq gated", irq, 0);
        cfg_enable = 1; @(negedge clk);
        chk("R8 req on", dma_req, 1);
        cpu_write(16'hBEEF);
        chk("R8 cpu ignored", busy, 0);
        mon_clear();
        dma_send(3, 16'hC000);
        chk("R7 done raw", irq_raw[2], 1);
        chk("R7 busy still high", busy, 1);
        chk("R9 done routed", irq_masked, 3'b100);
        pulse_clear(3'b100);
        wait_idle();
        chk("R7 dma words", rx_n, 3);
        chk("R7 dma word2", rx_words[2], 16'hC002);
        @(negedge clk); rx_overrun = 1; irq_clear = 3'b010;
        @(negedge clk); rx_overrun = 0; irq_clear = 0;
        chk("R11 set wins", irq_raw[1], 1);
        chk("R9 overrun routed", irq, 1);
        pulse_clear(3'b010);
        chk("R11 overrun cleared", irq_raw[1], 0);
    endtask

    task automatic t_dma_eot();
        cfg_eot_mode = 1; pulse_clear(3'b111); @(negedge clk);
        chk("R12 quiet start", irq, 0);
        mon_clear();
        dma_send(2, 16'hD100);
        chk("R12 first irq", irq, 1);
        chk("R12 first is done", irq_masked, 3'b100);
        chk("R12 busy at first", busy, 1);
        pulse_clear(3'b100);
        chk("R12 irq dropped", irq, 0);
        wait_idle();
        chk("R12 second is eot", irq_masked, 3'b001);
        chk("R12 two edges", irq_rises, 2);
        chk("R12 words", rx_words[1], 16'hD101);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_cpu_words();
        t_divider();
        t_level();
        t_eot();
        t_dma();
        t_dma_eot();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule